// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block takes one interrupt request that an upstream request engine is servicing and turns it into signals for the processors. The request carries the source pin, an 8-bit destination, an addressing mode, a delivery mode, a vector and a trigger mode. The block first works out which processors the destination addresses. Each processor slot describes itself with a present flag, a 4-bit physical identifier, an 8-bit logical group identifier, a priority value and a ready flag. The block then raises per-processor pulses that match the delivery mode.

The result is registered. One clock edge after a request is sampled, the block shows a `done` strobe, the interrupt or NMI pulse vectors, the echoed vector and trigger mode, and a `success` flag. The request engine uses `success` to decide whether a level-triggered entry now waits for an end-of-interrupt. Acceptance inside the processors is handled elsewhere. Here it is modelled only by the ready flag that is sampled together with the request.

Top module: `dsp_irq_dispatch`

## Requirements
- R1: In physical addressing mode (`req_logical`=0), a destination of 8'hFF selects every processor whose present flag is set.
- R2: In physical addressing mode with any other destination, the target is only the lowest-indexed present processor whose physical ID, zero-extended to 8 bits, equals the destination. Absent processors never match.
- R3: In logical addressing mode (`req_logical`=1), a destination of 0 selects nothing. Any other destination selects every present processor whose logical ID ANDed with the destination is nonzero.
- R4: When the target set is empty, `done` still pulses, no interrupt or NMI pulse is raised, and `success` is 0.
- R5: Fixed delivery (`req_dmode`=3'b000) raises `irq_pulse` for every processor in the target set, all in the same cycle. `out_vector` and `out_level` carry the request's vector and trigger mode.
- R6: Lowest-priority delivery (`req_dmode`=3'b001) raises exactly one `irq_pulse` bit. It goes to the target with the numerically smallest priority value, and a tie goes to the lower index.
- R7: For a request from pin 0 with a non-empty target set, fixed and lowest-priority delivery both pulse only processor 0.
- R8: NMI delivery (`req_dmode`=3'b100) raises `nmi_pulse` for every processor in the target set and no `irq_pulse`. `success` is 0.
- R9: Any other delivery mode code produces no pulse and `success`=0, while `done` still pulses.
- R10: `success` is 1 exactly when a fixed or lowest-priority interrupt was sent to at least one processor whose ready flag was set when the request was sampled.
- R11: All outputs are registered. They appear one cycle after `req_valid` is sampled and last one cycle. With no request, and after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_pin | input | PIN_W | Source pin index of the request |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| req_dmode | input | 3 | Delivery mode code |
| req_vector | input | 8 | Interrupt vector |
| req_level | input | 1 | Trigger mode, 1 = level |
| cpu_present | input | NCPU | Per-processor present flag |
| cpu_phys_id | input | NCPU*4 | Packed physical IDs, slot i at bits [4i+3:4i] |
| cpu_log_id | input | NCPU*8 | Packed logical IDs, slot i at bits [8i+7:8i] |
| cpu_prio | input | NCPU*PRIO_W | Packed priority values, lower value wins |
| cpu_ready | input | NCPU | Processor would accept an interrupt now |
| irq_pulse | output | NCPU | One-cycle interrupt pulse per processor |
| nmi_pulse | output | NCPU | One-cycle NMI pulse per processor |
| out_vector | output | 8 | Vector that goes with `irq_pulse` |
| out_level | output | 1 | Trigger mode that goes with `irq_pulse` |
| done | output | 1 | Request has been handled |
| success | output | 1 | Interrupt was accepted by a processor |

## Verification
A request that the bench drives on a falling edge is sampled at the next rising edge. Every result of that request (`done`, both pulse vectors, the vector, the trigger mode and `success`) is registered there and is due one cycle after the request. The bench drives each request on a falling edge and reads all outputs at the following falling edge, halfway through the cycle the results occupy. It withdraws the request at that same moment. After the test sequence, one idle cycle is checked to confirm the outputs fall back to zero.

// File: rtl/dsp_irq_pkg.sv
package dsp_irq_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWEST = 3'b001,
        DM_NMI    = 3'b100
    } dmode_e;

    localparam int DEST_W      = 8;
    localparam int VEC_W       = 8;
    localparam int PID_W       = 4;
    localparam int LID_W       = 8;
    localparam logic [DEST_W-1:0] DEST_ALL = 8'hFF;

endpackage

// File: rtl/dsp_target_sel.sv
module dsp_target_sel
    import dsp_irq_pkg::*;
#(
    parameter int NCPU = 16
) (
    input  logic [DEST_W-1:0]     dest,
    input  logic                  logical,
    input  logic [NCPU-1:0]       present,
    input  logic [NCPU*PID_W-1:0] phys_id,
    input  logic [NCPU*LID_W-1:0] log_id,
    output logic [NCPU-1:0]       mask
);

    logic [NCPU-1:0] phys_hit;
    logic [NCPU-1:0] log_hit;
    logic [NCPU-1:0] phys_first;

    genvar gi;
    generate
        for (gi = 0; gi < NCPU; gi++) begin : g_slot
            assign phys_hit[gi] = present[gi] &&
                (dest == {{(DEST_W-PID_W){1'b0}}, phys_id[gi*PID_W +: PID_W]});
            assign log_hit[gi]  = present[gi] &&
                ((dest & log_id[gi*LID_W +: LID_W]) != '0);
        end
    endgenerate

    // isolate lowest set bit: first matching processor wins
    assign phys_first = phys_hit & (~phys_hit + NCPU'(1));

    always_comb begin
        if (!logical) begin
            mask = (dest == DEST_ALL) ? present : phys_first;
        end else begin
            mask = (dest == '0) ? '0 : log_hit;
        end
    end

endmodule

// File: rtl/dsp_min_prio.sv
module dsp_min_prio #(
    parameter int NCPU   = 16,
    parameter int PRIO_W = 4
) (
    input  logic [NCPU-1:0]        cand,
    input  logic [NCPU*PRIO_W-1:0] prio,
    output logic [NCPU-1:0]        pick
);

    localparam int IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [PRIO_W-1:0] best_p;
    logic [IDX_W-1:0]  best_i;
    logic              found;

    always_comb begin
        best_p = '0;
        best_i = '0;
        found  = 1'b0;
        for (int i = 0; i < NCPU; i++) begin
            // strict compare keeps the lower index on a tie
            if (cand[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best_p)) begin
                best_p = prio[i*PRIO_W +: PRIO_W];
                best_i = IDX_W'(i);
                found  = 1'b1;
            end
        end
        pick = '0;
        if (found) begin
            pick[best_i] = 1'b1;
        end
    end

endmodule

// File: rtl/dsp_irq_dispatch.sv
module dsp_irq_dispatch
    import dsp_irq_pkg::*;
#(
    parameter int NCPU   = 16,
    parameter int PRIO_W = 4,
    parameter int PIN_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [PIN_W-1:0]        req_pin,
    input  logic [DEST_W-1:0]       req_dest,
    input  logic                    req_logical,
    input  logic [2:0]              req_dmode,
    input  logic [VEC_W-1:0]        req_vector,
    input  logic                    req_level,
    input  logic [NCPU-1:0]         cpu_present,
    input  logic [NCPU*PID_W-1:0]   cpu_phys_id,
    input  logic [NCPU*LID_W-1:0]   cpu_log_id,
    input  logic [NCPU*PRIO_W-1:0]  cpu_prio,
    input  logic [NCPU-1:0]         cpu_ready,
    output logic [NCPU-1:0]         irq_pulse,
    output logic [NCPU-1:0]         nmi_pulse,
    output logic [VEC_W-1:0]        out_vector,
    output logic                    out_level,
    output logic                    done,
    output logic                    success
);

    localparam logic [NCPU-1:0] CPU0_ONLY = NCPU'(1);

    typedef struct packed {
        logic [NCPU-1:0]  irq;
        logic [NCPU-1:0]  nmi;
        logic [VEC_W-1:0] vector;
        logic             level;
        logic             done;
        logic             success;
    } out_t;

    out_t            st_d, st_q;
    logic [NCPU-1:0] tgt_mask;
    logic [NCPU-1:0] low_pick;
    logic            pin_zero;

    dsp_target_sel #(.NCPU(NCPU)) u_sel (
        .dest    (req_dest),
        .logical (req_logical),
        .present (cpu_present),
        .phys_id (cpu_phys_id),
        .log_id  (cpu_log_id),
        .mask    (tgt_mask)
    );

    dsp_min_prio #(.NCPU(NCPU), .PRIO_W(PRIO_W)) u_pick (
        .cand (tgt_mask),
        .prio (cpu_prio),
        .pick (low_pick)
    );

    assign pin_zero = (req_pin == '0);

    always_comb begin
        logic [NCPU-1:0] sent;
        st_d = '0;
        sent = '0;
        if (req_valid) begin
            st_d.done   = 1'b1;
            st_d.vector = req_vector;
            st_d.level  = req_level;
            if (tgt_mask != '0) begin
                case (req_dmode)
                    DM_FIXED:  sent = pin_zero ? CPU0_ONLY : tgt_mask;
                    DM_LOWEST: sent = pin_zero ? CPU0_ONLY : low_pick;
                    DM_NMI:    st_d.nmi = tgt_mask;
                    default:   sent = '0;
                endcase
            end
            st_d.irq     = sent;
            st_d.success = ((sent & cpu_ready) != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_pulse  = st_q.irq;
    assign nmi_pulse  = st_q.nmi;
    assign out_vector = st_q.vector;
    assign out_level  = st_q.level;
    assign done       = st_q.done;
    assign success    = st_q.success;

endmodule

// File: rtl/dsp_irq_dispatch_chk.sv
module dsp_irq_dispatch_chk #(
    parameter int NCPU  = 16,
    parameter int PIN_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [PIN_W-1:0]  req_pin,
    input logic [2:0]        req_dmode,
    input logic [NCPU-1:0]   cpu_present,
    input logic [NCPU-1:0]   irq_pulse,
    input logic [NCPU-1:0]   nmi_pulse,
    input logic              done,
    input logic              success
);

    // R11: a sampled request is answered on the next cycle
    assert_done_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    // R11: without a request nothing is driven
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!done && irq_pulse == '0 && nmi_pulse == '0 && !success));

    // R6: lowest priority never reaches more than one processor
    assert_lowest_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dmode == 3'b001) |=> ($countones(irq_pulse) <= 1));

    // R8: NMI and interrupt pulses are never mixed
    assert_nmi_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse == '0) || (nmi_pulse == '0));

    // R10: success requires an interrupt pulse
    assert_success_has_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        success |-> (irq_pulse != '0));

    // R7: pin 0 only ever targets processor 0
    assert_pin0_cpu0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pin == '0) |=> ((irq_pulse >> 1) == '0));

    // R2: on other pins pulses only reach present processors
    assert_present_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pin != '0) |=>
            (((irq_pulse | nmi_pulse) & ~$past(cpu_present)) == '0));

endmodule

bind dsp_irq_dispatch dsp_irq_dispatch_chk #(.NCPU(NCPU), .PIN_W(PIN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_pin     (req_pin),
    .req_dmode   (req_dmode),
    .cpu_present (cpu_present),
    .irq_pulse   (irq_pulse),
    .nmi_pulse   (nmi_pulse),
    .done        (done),
    .success     (success)
);

// File: tb/sim_dsp_irq_dispatch.sv
`timescale 1ns/1ps
module sim_dsp_irq_dispatch;

    localparam int NCPU   = 16;
    localparam int PRIO_W = 4;
    localparam int PIN_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [PIN_W-1:0]  req_pin = '0;
    logic [7:0]        req_dest = '0;
    logic              req_logical = 1'b0;
    logic [2:0]        req_dmode = '0;
    logic [7:0]        req_vector = '0;
    logic              req_level = 1'b0;
    logic [NCPU-1:0]   cpu_present;
    logic [NCPU*4-1:0] cpu_phys_id;
    logic [NCPU*8-1:0] cpu_log_id;
    logic [NCPU*PRIO_W-1:0] cpu_prio;
    logic [NCPU-1:0]   cpu_ready;
    logic [NCPU-1:0]   irq_pulse, nmi_pulse;
    logic [7:0]        out_vector;
    logic              out_level, done, success;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dsp_irq_dispatch #(.NCPU(NCPU), .PRIO_W(PRIO_W), .PIN_W(PIN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pin(req_pin),
        .req_dest(req_dest), .req_logical(req_logical), .req_dmode(req_dmode),
        .req_vector(req_vector), .req_level(req_level),
        .cpu_present(cpu_present), .cpu_phys_id(cpu_phys_id),
        .cpu_log_id(cpu_log_id), .cpu_prio(cpu_prio), .cpu_ready(cpu_ready),
        .irq_pulse(irq_pulse), .nmi_pulse(nmi_pulse), .out_vector(out_vector),
        .out_level(out_level), .done(done), .success(success)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one request at a falling edge, sample results one cycle later
    task automatic run_req(input string req, input logic [PIN_W-1:0] pin,
                           input logic [7:0] dest, input logic logical,
                           input logic [2:0] dmode, input logic [7:0] vec,
                           input logic lvl, input logic [NCPU-1:0] exp_irq,
                           input logic [NCPU-1:0] exp_nmi, input logic exp_ok);
        @(negedge clk);
        req_valid = 1'b1; req_pin = pin; req_dest = dest; req_logical = logical;
        req_dmode = dmode; req_vector = vec; req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, "irq_pulse", 32'(irq_pulse), 32'(exp_irq));
        check(req, "nmi_pulse", 32'(nmi_pulse), 32'(exp_nmi));
        check(req, "success",   32'(success),   32'(exp_ok));
        check("R11", "done",    32'(done),      32'd1);
        if (exp_irq != '0) begin
            check("R5", "out_vector", 32'(out_vector), 32'(vec));
            check("R5", "out_level",  32'(out_level),  32'(lvl));
        end
    endtask

    task automatic t_reset;
        check("R11", "reset irq",  32'(irq_pulse), 32'd0);
        check("R11", "reset nmi",  32'(nmi_pulse), 32'd0);
        check("R11", "reset done", 32'(done),      32'd0);
    endtask

    task automatic t_physical;
        // R1: broadcast to all present (cpu3 absent)
        run_req("R1", 5'd5, 8'hFF, 1'b0, 3'b000, 8'h41, 1'b0, 16'hFFF7, '0, 1'b1);
        // R2: cpu2 and cpu7 both carry ID 2, first wins
        run_req("R2", 5'd5, 8'h02, 1'b0, 3'b000, 8'h42, 1'b1, 16'h0004, '0, 1'b1);
        // R2/R4: only absent cpu3 carries ID 3
        run_req("R4", 5'd5, 8'h03, 1'b0, 3'b000, 8'h43, 1'b0, 16'h0000, '0, 1'b0);
        // R2: 8'h12 is not a zero-extended ID
        run_req("R2", 5'd5, 8'h12, 1'b0, 3'b000, 8'h44, 1'b0, 16'h0000, '0, 1'b0);
    endtask

    task automatic t_logical;
        // R3/R5: groups 0 and 2 -> cpus 0,2,8,10
        run_req("R3", 5'd6, 8'h05, 1'b1, 3'b000, 8'h51, 1'b0, 16'h0505, '0, 1'b1);
        // R3: group 3 -> cpu3 absent, cpu11 only
        run_req("R3", 5'd6, 8'h08, 1'b1, 3'b000, 8'h52, 1'b0, 16'h0800, '0, 1'b1);
        // R3/R4: zero destination selects nobody
        run_req("R4", 5'd6, 8'h00, 1'b1, 3'b000, 8'h53, 1'b0, 16'h0000, '0, 1'b0);
    endtask

    task automatic t_lowest;
        // R6: prios 15,5,7,5 -> tie between cpu2 and cpu10, cpu2 wins
        run_req("R6", 5'd7, 8'h05, 1'b1, 3'b001, 8'h61, 1'b1, 16'h0004, '0, 1'b1);
        // R6: cpu0 prio 15, cpu8 prio 7 -> cpu8
        run_req("R6", 5'd7, 8'h01, 1'b1, 3'b001, 8'h62, 1'b0, 16'h0100, '0, 1'b1);
    endtask

    task automatic t_pin0;
        // R7: fixed broadcast from pin 0
        run_req("R7", 5'd0, 8'hFF, 1'b0, 3'b000, 8'h71, 1'b0, 16'h0001, '0, 1'b1);
        // R7: lowest from pin 0, targets cpus 2,10
        run_req("R7", 5'd0, 8'h04, 1'b1, 3'b001, 8'h72, 1'b0, 16'h0001, '0, 1'b1);
    endtask

    task automatic t_nmi_other;
        // R8: NMI to cpus 0,2,8,10
        run_req("R8", 5'd9, 8'h05, 1'b1, 3'b100, 8'h81, 1'b0, 16'h0000, 16'h0505, 1'b0);
        // R9: unsupported mode code
        run_req("R9", 5'd9, 8'hFF, 1'b0, 3'b010, 8'h82, 1'b0, 16'h0000, 16'h0000, 1'b0);
        run_req("R9", 5'd9, 8'hFF, 1'b0, 3'b111, 8'h83, 1'b0, 16'h0000, 16'h0000, 1'b0);
    endtask

    task automatic t_success;
        cpu_ready[2] = 1'b0;
        // R10: target not ready -> pulse but no success
        run_req("R10", 5'd5, 8'h02, 1'b0, 3'b000, 8'h91, 1'b0, 16'h0004, '0, 1'b0);
        // R10: broadcast, other processors ready
        run_req("R10", 5'd5, 8'hFF, 1'b0, 3'b000, 8'h92, 1'b0, 16'hFFF7, '0, 1'b1);
        cpu_ready = '1;
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R11", "idle done", 32'(done),      32'd0);
        check("R11", "idle irq",  32'(irq_pulse), 32'd0);
        check("R11", "idle nmi",  32'(nmi_pulse), 32'd0);
    endtask

    initial begin
        cpu_present = 16'hFFF7;
        cpu_ready   = '1;
        for (int i = 0; i < NCPU; i++) begin
            cpu_phys_id[i*4 +: 4]      = 4'(i);
            cpu_log_id[i*8 +: 8]       = 8'(1) << (i % 8);
            cpu_prio[i*PRIO_W +: PRIO_W] = PRIO_W'(15 - i);
        end
        cpu_phys_id[7*4 +: 4]      = 4'd2;
        cpu_prio[2*PRIO_W +: PRIO_W] = 4'd5;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_physical();
        t_logical();
        t_lowest();
        t_pin0();
        t_nmi_other();
        t_success();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule